// File: doc/BRIEF.md
# Masked Popcount Rank Unit

This block turns an 8-bit seed value into its position inside the set of seeds that belong to one sine code. Each of 29 sine codes owns a 256-bit membership row in which bit j is one when seed value j is a member of that code's set. A lookup names a code and a seed. The unit fetches that code's row, clears every bit at or above the seed, counts the surviving ones in 8-bit groups and sums the 32 group counts in a balanced adder tree. The result is the number of set members smaller than the seed, which serves as a compact index in place of the full seed.

The datapath has three registered stages: row fetch, mask plus group count, and adder tree. It accepts one lookup per clock and answers after a fixed latency. A separate registered write port loads whole membership rows. Each answer also reports whether the seed itself is a member of the row, and an error flag for code indices that have no row.

Top module: `masked_rank_unit`

## Requirements
- R1: For a valid code, `out_rank` equals the number of one bits of the selected row at bit positions strictly below `in_seed` (bit j stands for seed value j). The smallest member of a set therefore gets rank 0, and with members {4, 5, 6} the seed 6 gets rank 2.
- R2: A lookup sampled with `in_valid` high at a rising edge produces `out_valid` high after exactly three rising edges, with one lookup accepted every cycle. `out_valid` is low in every other cycle.
- R3: When `wr_en` is high at a rising edge and `wr_row` is 28 or less, row `wr_row` takes the value of `wr_data` at that edge. A lookup sampled at the same edge still sees the previous contents, and lookups sampled at later edges see the new contents.
- R4: `out_member` equals bit `in_seed` of the selected row. This bit does not contribute to `out_rank`.
- R5: Synchronous active-high reset clears all 29 rows and all pipeline stages. After reset, `out_valid`, `out_rank`, `out_member` and `out_err` are zero, and any lookup returns rank 0 with the member flag low.
- R6: A write changes only the addressed row. Lookups on all other rows return the same results as before the write.
- R7: A lookup whose code index is above 28 returns rank 0, the member flag low and `out_err` high. For a code of 28 or less, `out_err` is low.
- R8: A write whose row index is above 28 has no effect on any stored row.
- R9: With a row of all ones, seed 255 gives rank 255 with the member flag high, and seed 0 gives rank 0 with the member flag high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Row write enable |
| wr_row | input | 5 | Row index to write (0 to 28 take effect) |
| wr_data | input | 256 | New membership row, bit j for seed value j |
| in_valid | input | 1 | Lookup request valid |
| in_code | input | 5 | Sine code index selecting the row |
| in_seed | input | 8 | Seed value to rank |
| out_valid | output | 1 | Result valid, three cycles after the request |
| out_rank | output | 9 | Count of set members below the seed |
| out_member | output | 1 | Seed's own bit in the selected row |
| out_err | output | 1 | Code index had no row |

## Verification
The case that is hardest to reach from the ports is a write and a lookup to the same row at the same clock edge, where the answer must still reflect the old row while the next lookup sees the new one. The bench drives this directly in one cycle and follows it with a lookup of the same row. Random traffic then mixes writes of sparse and dense rows with lookups every cycle, so writes often land one or two cycles before a lookup of the same row. The bench also places seeds at the group edges and at 0 and 255 so that the mask boundary falls on every kind of position.

// File: rtl/rank_pkg.sv
package rank_pkg;

    localparam int NUM_ROWS = 29;
    localparam int ROW_W    = 256;
    localparam int GRP_W    = 8;

    localparam int NUM_GRP  = ROW_W / GRP_W;
    localparam int LEVELS   = $clog2(NUM_GRP);
    localparam int CODE_W   = $clog2(NUM_ROWS);
    localparam int SEED_W   = $clog2(ROW_W);
    localparam int CNT_W    = $clog2(GRP_W + 1);
    localparam int RANK_W   = $clog2(ROW_W + 1);

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [SEED_W-1:0] seed_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [RANK_W-1:0] rank_t;

    // Fetched row with its lookup context
    typedef struct packed {
        logic  vld;
        logic  err;
        seed_t seed;
        row_t  row;
    } fetch_t;

    // Group counts of the masked row
    typedef struct packed {
        logic                   vld;
        logic                   err;
        logic                   member;
        cnt_t [NUM_GRP-1:0]     cnts;
    } count_t;

    // Ones strictly below position s
    function automatic row_t below_mask(input seed_t s);
        return (ROW_W'(1) << s) - ROW_W'(1);
    endfunction

    // Ones in one group; maps to a small table per group
    function automatic cnt_t grp_ones(input logic [GRP_W-1:0] v);
        cnt_t c;
        c = '0;
        for (int i = 0; i < GRP_W; i++) begin
            c = c + CNT_W'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/rank_row_store.sv
module rank_row_store
    import rank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  code_t  wr_row,
    input  row_t   wr_data,
    input  logic   rd_valid,
    input  code_t  rd_code,
    input  seed_t  rd_seed,
    output fetch_t fetch_q
);

    row_t mem [NUM_ROWS];

    logic wr_ok;
    logic rd_ok;

    assign wr_ok = wr_en && (int'(wr_row) < NUM_ROWS);
    assign rd_ok = int'(rd_code) < NUM_ROWS;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                mem[r] <= '0;
            end
        end else if (wr_ok) begin
            mem[wr_row] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= '0;
        end else begin
            fetch_q.vld  <= rd_valid;
            fetch_q.err  <= rd_valid && !rd_ok;
            fetch_q.seed <= rd_seed;
            fetch_q.row  <= (rd_valid && rd_ok) ? mem[rd_code] : '0;
        end
    end

    AST_BAD_CODE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ok) |=> (fetch_q.err && fetch_q.row == '0)) // R7
        else $error("bad code not flagged");

endmodule

// File: rtl/rank_mask_count.sv
module rank_mask_count
    import rank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fetch_t fetch_i,
    output count_t count_q
);

    row_t               masked;
    cnt_t [NUM_GRP-1:0] cnt_d;

    assign masked = fetch_i.row & below_mask(fetch_i.seed);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign cnt_d[g] = grp_ones(masked[g*GRP_W +: GRP_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q.vld    <= fetch_i.vld;
            count_q.err    <= fetch_i.err;
            count_q.member <= fetch_i.vld && fetch_i.row[fetch_i.seed];
            count_q.cnts   <= cnt_d;
        end
    end

    AST_ERR_CARRIED: assert property (@(posedge clk) disable iff (rst)
        count_q.err == $past(fetch_i.err)) // R7
        else $error("error flag lost in count stage");

endmodule

// File: rtl/rank_adder_tree.sv
module rank_adder_tree
    import rank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  count_t count_i,
    output logic   vld_q,
    output logic   err_q,
    output logic   member_q,
    output rank_t  rank_q
);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int N = NUM_GRP >> l;
        rank_t node [N];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_n
                assign node[i] = RANK_W'(count_i.cnts[i]);
            end
        end else begin : g_sum
            for (genvar i = 0; i < N; i++) begin : g_n
                assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            err_q    <= 1'b0;
            member_q <= 1'b0;
            rank_q   <= '0;
        end else begin
            vld_q    <= count_i.vld;
            err_q    <= count_i.err;
            member_q <= count_i.member;
            rank_q   <= g_lvl[LEVELS].node[0];
        end
    end

    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        vld_q == $past(count_i.vld)) // R2
        else $error("valid not carried through tree stage");

endmodule

// File: rtl/masked_rank_unit.sv
module masked_rank_unit
    import rank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CODE_W-1:0]    wr_row,
    input  logic [ROW_W-1:0]     wr_data,
    input  logic                 in_valid,
    input  logic [CODE_W-1:0]    in_code,
    input  logic [SEED_W-1:0]    in_seed,
    output logic                 out_valid,
    output logic [RANK_W-1:0]    out_rank,
    output logic                 out_member,
    output logic                 out_err
);

    fetch_t fetch_s;
    count_t count_s;

    rank_row_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_data  (wr_data),
        .rd_valid (in_valid),
        .rd_code  (in_code),
        .rd_seed  (in_seed),
        .fetch_q  (fetch_s)
    );

    rank_mask_count u_count (
        .clk     (clk),
        .rst     (rst),
        .fetch_i (fetch_s),
        .count_q (count_s)
    );

    rank_adder_tree u_tree (
        .clk      (clk),
        .rst      (rst),
        .count_i  (count_s),
        .vld_q    (out_valid),
        .err_q    (out_err),
        .member_q (out_member),
        .rank_q   (out_rank)
    );

    AST_ERR_ZERO_RANK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_rank == '0 && !out_member)) // R7
        else $error("error result carries data");

endmodule

// File: tb/masked_rank_unit_tb.sv
module masked_rank_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_row = '0;
    logic [255:0] wr_data = '0;
    logic         in_valid = 1'b0;
    logic [4:0]   in_code = '0;
    logic [7:0]   in_seed = '0;
    logic         out_valid;
    logic [8:0]   out_rank;
    logic         out_member;
    logic         out_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [255:0] mdl [29];

    logic         e_v   [3];
    int           e_r   [3];
    logic         e_m   [3];
    logic         e_e   [3];
    string        e_tag [3];

    always #2 clk = ~clk;

    masked_rank_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .in_valid(in_valid), .in_code(in_code), .in_seed(in_seed),
        .out_valid(out_valid), .out_rank(out_rank), .out_member(out_member), .out_err(out_err)
    );

    function automatic int ref_rank(input logic [255:0] row, input int s);
        int n = 0;
        for (int j = 0; j < s; j++) n += int'(row[j]);
        return n;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_out();
        chk("R2", "out_valid", int'(out_valid), int'(e_v[2]));
        if (e_v[2]) begin
            chk(e_tag[2], "rank", int'(out_rank), e_r[2]);
            chk("R4", "member", int'(out_member), int'(e_m[2]));
            chk("R7", "err", int'(out_err), int'(e_e[2]));
        end
    endtask

    task automatic cyc(input logic we, input int wr, input logic [255:0] wd,
                       input logic v, input int c, input int s, input string tag);
        @(negedge clk);
        check_out();
        wr_en = we; wr_row = 5'(wr); wr_data = wd;
        in_valid = v; in_code = 5'(c); in_seed = 8'(s);
        for (int k = 2; k > 0; k--) begin
            e_v[k] = e_v[k-1]; e_r[k] = e_r[k-1]; e_m[k] = e_m[k-1];
            e_e[k] = e_e[k-1]; e_tag[k] = e_tag[k-1];
        end
        e_v[0] = v; e_tag[0] = tag;
        if (c > 28) begin
            e_r[0] = 0; e_m[0] = 1'b0; e_e[0] = 1'b1;
        end else begin
            e_r[0] = ref_rank(mdl[c], s); e_m[0] = mdl[c][s]; e_e[0] = 1'b0;
        end
        if (we && wr < 29) mdl[wr] = wd;
    endtask

    task automatic look(input int c, input int s, input string tag);
        cyc(1'b0, 0, '0, 1'b1, c, s, tag);
    endtask

    task automatic wr(input int r, input logic [255:0] d);
        cyc(1'b1, r, d, 1'b0, 0, 0, "R3");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, '0, 1'b0, 0, 0, "R2");
    endtask

    initial begin
        logic [255:0] set456;
        void'($urandom(32'h5eed_0042));
        for (int r = 0; r < 29; r++) mdl[r] = '0;
        for (int k = 0; k < 3; k++) begin
            e_v[k] = 1'b0; e_r[k] = 0; e_m[k] = 1'b0; e_e[k] = 1'b0; e_tag[k] = "R1";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R5: reset state at the ports
        chk("R5", "out_valid after reset", int'(out_valid), 0);
        chk("R5", "out_rank after reset", int'(out_rank), 0);
        chk("R5", "out_member after reset", int'(out_member), 0);
        chk("R5", "out_err after reset", int'(out_err), 0);
        look(0, 200, "R5");
        look(28, 255, "R5");
        idle(3);

        // R1: set {4,5,6} in row 3
        set456 = '0; set456[4] = 1'b1; set456[5] = 1'b1; set456[6] = 1'b1;
        wr(3, set456);
        look(3, 4, "R1");
        look(3, 5, "R1");
        look(3, 6, "R1");
        look(3, 7, "R1");
        look(3, 3, "R1");
        // R6: neighbours untouched
        look(2, 255, "R6");
        look(4, 255, "R6");
        // R7: codes without a row
        look(29, 10, "R7");
        look(31, 255, "R7");
        // R8: write to index 30 ignored; scan all rows
        cyc(1'b1, 30, '1, 1'b0, 0, 0, "R8");
        for (int r = 0; r < 29; r++) look(r, 255, "R8");
        // R3: write and lookup of one row at the same edge
        cyc(1'b1, 5, '1, 1'b1, 5, 100, "R3");
        look(5, 100, "R3");
        // R9: full row ends
        wr(28, '1);
        look(28, 255, "R9");
        look(28, 0, "R9");
        // group edges on a patterned row
        wr(7, {8{32'hA5C3_0F18}});
        for (int s = 0; s < 256; s += 8) begin
            look(7, s, "R1");
            look(7, s + 7, "R1");
        end
        idle(3);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [255:0] d;
            logic we;
            d = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            case ($urandom % 4)
                0: d = d & {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
                1: d = d | {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
                default: ;
            endcase
            we = ($urandom % 6) == 0;
            cyc(we, int'($urandom % 32), d, ($urandom % 5) != 0,
                int'($urandom % 32), int'($urandom % 256), we ? "R6" : "R1");
        end
        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule